// File: doc/BRIEF.md
# Reconfigurable NAND/NOR Gate Array

This block models a row of two-input logic cells whose function is not fixed when the chip is built. Each cell keeps two stored state bits: a NAND leg and a NOR leg. After reset both legs are cleared. In that state the cell is blank: its output is held at 0 and its blank flag is raised. The cell's function is then written once, after reset, using two global programming lines shared by all cells together with that cell's own data inputs.

A cycle programs the cells only when exactly one programming line is high. With line X high, a cell whose inputs read a=1, b=0 becomes a NAND. With line Y high, a cell whose inputs read a=0, b=1 becomes a NOR. Every cell looks at its own inputs, so the whole array is programmed in parallel. Two consecutive cycles are enough to load any mix of NAND and NOR cells. With both lines low the array is in normal operation, and each cell evaluates its stored function combinationally. Raising both lines at once is a misuse: it changes no cell and sets a sticky error flag.

Top module: `morph_gate_array`

## Requirements
- R1: After a synchronous active-low reset every cell is blank, every output is 0 and the error flag is 0.
- R2: At a clock edge with cfg_x=1, cfg_y=0, a cell whose inputs are a=1, b=0 stores the NAND function, and it keeps that function in later cycles.
- R3: At a clock edge with cfg_x=0, cfg_y=1, a cell whose inputs are a=0, b=1 stores the NOR function, and it keeps that function in later cycles.
- R4: With both programming lines low, the output of a NAND cell is ~(a&b) and the output of a NOR cell is ~(a|b). The output follows the cell's current inputs in the same cycle.
- R5: A blank cell drives output 0 for every input pair, and its blank flag is 1. The flag drops to 0 once the cell is programmed.
- R6: In a programming cycle (exactly one line high), a cell whose a/b pair is not the one defined for the active line keeps its stored state.
- R7: When both lines are 0, no cell's state changes, whatever its inputs do.
- R8: When both lines are 1, no cell's state changes and the error flag goes to 1. The flag stays at 1 until reset.
- R9: All cells are programmed in the same cycle, each one from its own inputs. A programmed cell can be written again to the other function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_x | input | 1 | Global programming line that selects NAND |
| cfg_y | input | 1 | Global programming line that selects NOR |
| in_a | input | NUM_CELLS | Input a, one bit per cell |
| in_b | input | NUM_CELLS | Input b, one bit per cell |
| out_y | output | NUM_CELLS | Cell outputs |
| blank | output | NUM_CELLS | Per-cell flag: the cell has not been programmed |
| ctl_err | output | 1 | Sticky flag: both programming lines were high together |

## Verification
The hardest situation to reach from the ports is a single programming cycle in which some cells change and their neighbours must not. The test sets up random mixes of three cell types. Cells meant to be NAND cells see a=1, b=0, cells meant to be NOR cells see a=0, b=1, and cells that should stay blank see a=0, b=0. Line X and then line Y are pulsed on the same input vectors, so during each pulse the cells aimed at the other function carry a pattern that must be ignored. The stored state is then read back by sweeping all four input pairs across the array, with the programming lines low.

// File: rtl/morph_pkg.sv
// Package: types shared by the reconfigurable gate array.
// Assumes: the two cell legs are never both set (the programming logic prevents it).
package morph_pkg;

    // Stored state of one cell: one bit per leg.
    typedef struct packed {
        logic nor_leg;
        logic nand_leg;
    } cell_state_t;

    // Decoded meaning of the two global programming lines.
    typedef enum logic [1:0] {
        PH_RUN      = 2'b00,
        PH_SET_NAND = 2'b01,
        PH_SET_NOR  = 2'b10,
        PH_FAULT    = 2'b11
    } phase_e;

endpackage

// File: rtl/morph_ctl_decode.sv
// Module: morph_ctl_decode
// Decodes the two global programming lines into an array-wide phase.
// Assumes: the lines are synchronous to clk. Both high is a misuse and decodes to PH_FAULT.
module morph_ctl_decode
    import morph_pkg::*;
(
    input  logic   cfg_x,
    input  logic   cfg_y,
    output phase_e phase
);

    // Map the line pair onto a phase.
    always_comb begin
        unique case ({cfg_y, cfg_x})
            2'b00:   phase = PH_RUN;
            2'b01:   phase = PH_SET_NAND;
            2'b10:   phase = PH_SET_NOR;
            default: phase = PH_FAULT;
        endcase
    end

endmodule

// File: rtl/morph_cell.sv
// Module: morph_cell
// One reconfigurable two-input cell. It holds a two-bit state, loaded by the
// array phase together with the cell's own inputs, and evaluates the stored
// function combinationally.
// Assumes: synchronous active-low reset. The state is changed only in a valid programming phase.
module morph_cell
    import morph_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   a,
    input  logic   b,
    output logic   y,
    output logic   blank
);

    cell_state_t state_q;
    cell_state_t state_d;
    logic        hit_nand;
    logic        hit_nor;

    // Detect the two defined programming patterns.
    always_comb begin
        hit_nand = (phase == PH_SET_NAND) && a && !b;
        hit_nor  = (phase == PH_SET_NOR) && !a && b;
    end

    // Pick the next state. Every other case holds the current state.
    always_comb begin
        state_d = state_q;
        if (hit_nand) begin
            state_d.nand_leg = 1'b1;
            state_d.nor_leg  = 1'b0;
        end else if (hit_nor) begin
            state_d.nand_leg = 1'b0;
            state_d.nor_leg  = 1'b1;
        end
    end

    // State register with synchronous reset to blank.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Evaluate the stored function. A blank cell drives 0.
    always_comb begin
        unique case ({state_q.nor_leg, state_q.nand_leg})
            2'b01:   y = ~(a & b);
            2'b10:   y = ~(a | b);
            default: y = 1'b0;
        endcase
        blank = !state_q.nand_leg && !state_q.nor_leg;
    end

    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state_q.nor_leg, state_q.nand_leg}));   // R9
    AST_NAND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SET_NAND && a && !b) |=> (y == ~(a & b)) && !blank);   // R2
    AST_NOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SET_NOR && !a && b) |=> (y == ~(a | b)) && !blank);   // R3
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |=> $stable(state_q));   // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FAULT) |=> $stable(state_q));   // R8
    AST_BAD_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SET_NAND && !(a && !b)) |=> $stable(state_q));   // R6
    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (y == 1'b0));   // R5

endmodule

// File: rtl/morph_err_flag.sv
// Module: morph_err_flag
// Sticky flag, raised by any cycle in which both programming lines are high.
// Assumes: only reset clears the flag.
module morph_err_flag
    import morph_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    output logic   err
);

    // Set on a fault phase and hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (phase == PH_FAULT) err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);   // R8
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FAULT) |=> err);   // R8

endmodule

// File: rtl/morph_gate_array.sv
// Module: morph_gate_array
// Top of the array. It holds NUM_CELLS reconfigurable NAND/NOR cells, which
// share one decoder for the programming lines, plus the sticky misuse flag.
// Assumes: the programming lines and the cell inputs are synchronous to clk.
module morph_gate_array
    import morph_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_x,
    input  logic                 cfg_y,
    input  logic [NUM_CELLS-1:0] in_a,
    input  logic [NUM_CELLS-1:0] in_b,
    output logic [NUM_CELLS-1:0] out_y,
    output logic [NUM_CELLS-1:0] blank,
    output logic                 ctl_err
);

    localparam int LAST_CELL = NUM_CELLS - 1;

    phase_e phase;

    morph_ctl_decode u_decode (
        .cfg_x (cfg_x),
        .cfg_y (cfg_y),
        .phase (phase)
    );

    morph_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .err   (ctl_err)
    );

    for (genvar i = 0; i <= LAST_CELL; i++) begin : g_cell
        morph_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .a     (in_a[i]),
            .b     (in_b[i]),
            .y     (out_y[i]),
            .blank (blank[i])
        );
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (blank == '1) && !ctl_err);   // R1

endmodule

// File: tb/morph_gate_array_test.sv
module morph_gate_array_test;

    localparam int CLK_PERIOD = 40;
    localparam int N          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_x = 1'b0;
    logic         cfg_y = 1'b0;
    logic [N-1:0] in_a = '0;
    logic [N-1:0] in_b = '0;
    logic [N-1:0] out_y;
    logic [N-1:0] blank;
    logic         ctl_err;

    int checks = 0;
    int errors = 0;
    int exp_fn [N];   // 0 blank, 1 NAND, 2 NOR

    morph_gate_array #(.NUM_CELLS(N)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_x(cfg_x), .cfg_y(cfg_y),
        .in_a(in_a), .in_b(in_b), .out_y(out_y), .blank(blank), .ctl_err(ctl_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic model_y(int fn, logic a, logic b);
        if (fn == 1) return ~(a & b);
        if (fn == 2) return ~(a | b);
        return 1'b0;
    endfunction

    // Compare every cell against the model over all pairs plus random vectors.
    task automatic check_cells(string req);
        for (int p = 0; p < 8; p++) begin
            if (p < 4) begin
                in_a = {N{p[1]}};
                in_b = {N{p[0]}};
            end else begin
                in_a = N'($urandom);
                in_b = N'($urandom);
            end
            #1;
            for (int i = 0; i < N; i++) begin
                check_bit(req, $sformatf("out_y[%0d] a=%0b b=%0b", i, in_a[i], in_b[i]),
                          out_y[i], model_y(exp_fn[i], in_a[i], in_b[i]));
                check_bit(req, $sformatf("blank[%0d]", i), blank[i], exp_fn[i] == 0);
            end
        end
    endtask

    // One programming cycle, followed by the lines returning to 0.
    task automatic prog_cycle(logic x, logic y, logic [N-1:0] a, logic [N-1:0] b);
        @(negedge clk);
        cfg_x = x; cfg_y = y; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        cfg_x = 1'b0; cfg_y = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_x = 1'b0; cfg_y = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) exp_fn[i] = 0;
    endtask

    task automatic test_reset();
        do_reset();
        #1;
        check_bit("R1", "ctl_err", ctl_err, 1'b0);
        check_cells("R1_R5");
    endtask

    // Wrong pairs during a programming cycle must leave blank cells blank.
    task automatic test_ignored_pairs();
        prog_cycle(1'b1, 1'b0, '1, '1);
        prog_cycle(1'b1, 1'b0, '0, '0);
        prog_cycle(1'b1, 1'b0, '0, '1);
        prog_cycle(1'b0, 1'b1, '1, '0);
        prog_cycle(1'b0, 1'b1, '1, '1);
        prog_cycle(1'b0, 1'b1, '0, '0);
        check_cells("R6");
        check_bit("R6", "ctl_err", ctl_err, 1'b0);
    endtask

    // Random mix programmed in parallel: X pulse then Y pulse on the same vectors.
    task automatic test_random_mix(int rounds);
        for (int r = 0; r < rounds; r++) begin
            logic [N-1:0] a;
            logic [N-1:0] b;
            int           pick [N];
            for (int i = 0; i < N; i++) begin
                pick[i] = int'($urandom_range(2, 0));
                a[i] = (pick[i] == 1);
                b[i] = (pick[i] == 2);
                if (pick[i] != 0) exp_fn[i] = pick[i];
            end
            prog_cycle(1'b1, 1'b0, a, b);
            prog_cycle(1'b0, 1'b1, a, b);
            check_cells("R2_R3_R4_R9");
        end
    endtask

    // Inputs toggle over many cycles with the lines low: the state must hold.
    task automatic test_run_hold();
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            in_a = N'($urandom);
            in_b = N'($urandom);
        end
        @(negedge clk);
        check_cells("R7");
    endtask

    // Write every cell to the opposite function.
    task automatic test_rewrite();
        logic [N-1:0] a;
        logic [N-1:0] b;
        for (int i = 0; i < N; i++) begin
            exp_fn[i] = (exp_fn[i] == 1) ? 2 : 1;
            a[i] = (exp_fn[i] == 1);
            b[i] = (exp_fn[i] == 2);
        end
        prog_cycle(1'b1, 1'b0, a, b);
        prog_cycle(1'b0, 1'b1, a, b);
        check_cells("R9");
    endtask

    // Both lines high: no change, error is set and stays until reset.
    task automatic test_fault();
        prog_cycle(1'b1, 1'b1, '1, '0);
        prog_cycle(1'b1, 1'b1, '0, '1);
        #1;
        check_bit("R8", "ctl_err after fault", ctl_err, 1'b1);
        check_cells("R8");
        prog_cycle(1'b0, 1'b1, '0, '1);
        for (int i = 0; i < N; i++) exp_fn[i] = 2;
        #1;
        check_bit("R8", "ctl_err sticky", ctl_err, 1'b1);
        check_cells("R3");
        do_reset();
        #1;
        check_bit("R1", "ctl_err cleared by reset", ctl_err, 1'b0);
        check_cells("R1");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_ignored_pairs();
        test_random_mix(6);
        test_run_hold();
        test_rewrite();
        test_fault();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule